// File: doc/BRIEF.md
# Product-Term Macrocell with Term Allocator

This block is one output cell of a sum-of-products logic array. It receives a small set of direct product terms from an AND plane, plus a few terms lent by neighbouring cells, and turns them into one output bit, a feedback bit and an output-enable bit. A per-term role code decides what each direct term does. It can feed the OR sum, clock the cell's flip-flop, force the flip-flop high or low at once, or gate the output enable.

The OR sum passes through an XOR with a configurable constant, which sets the data polarity. The result is either stored or passed straight through. The storage element works as a D flip-flop, as a toggle flip-flop, or is bypassed so the output follows the logic without a clock. The flip-flop clock is one of several global clocks, each usable in either polarity, or a clock built from product terms. A power-on input and a global set/reset input both load a configurable preload value.

All configuration arrives on static ports, so one design can be placed many times and each copy given its own setting.

Top module: `mc_macrocell`

## Requirements
- R1: The role of direct term i is the 3-bit code at `cfg_role[3i+2:3i]`: 0 data, 1 clock, 2 async set, 3 async reset, 4 output enable. Codes 5 to 7 leave the term unused, so it affects no output.
- R2: The data value is the OR of all data-role direct terms and all `share_in` bits, exclusive-ORed with `cfg_xor`.
- R3: A direct term with any non-data role never contributes to the data value.
- R4: With `cfg_mode` = 0 (D), on each active edge of the selected clock the flip-flop loads the data value, and `mc_out` equals `mc_fb`.
- R5: With `cfg_mode` = 1 (toggle), on each active edge the flip-flop inverts when the data value is 1 and holds when it is 0.
- R6: With `cfg_mode` = 2 or 3 (bypass), `mc_out` follows the data value with no clock edge. `mc_fb` still shows the flip-flop.
- R7: While any set-role term is 1, `mc_fb` is 1 at once, without a clock. While any reset-role term is 1, `mc_fb` is 0, and reset wins over set.
- R8: While `por_n` is 0 or `gsr` is 1, `mc_fb` equals `cfg_preload`. This overrides the set-role and reset-role terms.
- R9: `cfg_clk_src` values 0 to 2 select global clock `gclk[n]`, and value 3 selects the OR of the clock-role terms. Edges on a clock that is not selected do not change the flip-flop.
- R10: With `cfg_clk_inv` = 1, a selected global clock is active on its falling edge, and its rising edge does nothing.
- R11: `mc_oe` is the OR of the output-enable-role terms. When no term has that role, `mc_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on initialisation, active low; loads the preload value |
| gsr | input | 1 | Global set/reset, active high; loads the preload value |
| gclk | input | N_GCLK | Global clocks |
| pt | input | N_PT | Direct product terms from the AND plane |
| share_in | input | N_SHARE | Product terms lent by neighbouring cells, always data |
| cfg_role | input | 3*N_PT | Role code of each direct term |
| cfg_clk_src | input | SRC_W | Clock source: global index, or N_GCLK for the term clock |
| cfg_clk_inv | input | 1 | Use the selected global clock on its falling edge |
| cfg_mode | input | 2 | 0 D, 1 toggle, 2/3 bypass |
| cfg_xor | input | 1 | Polarity constant applied to the OR sum |
| cfg_preload | input | 1 | Value loaded at power-on and by `gsr` |
| mc_out | output | 1 | Cell output |
| mc_fb | output | 1 | Flip-flop state, for feedback |
| mc_oe | output | 1 | Output enable |

## Verification
The checker samples every cycle of `gclk[0]`. On each such cycle it confirms that an active reset term holds the flip-flop at 0 even when a set term is also active, and that a set term alone holds it at 1. It also confirms that `gsr` pins it to the preload value and that the output enable follows its role rules. Which clock edge captures data, the toggle behaviour, and the excluding of control terms from the sum all depend on the order of events. Only the bench's directed scenarios show these: unselected clocks, falling-edge use, term clocks, and unused role codes.

// File: rtl/mc_pkg.sv
package mc_pkg;
   localparam int ROLE_W = 3;

   typedef enum logic [ROLE_W-1:0] {
      ROLE_DATA = 3'd0,
      ROLE_CLK  = 3'd1,
      ROLE_SET  = 3'd2,
      ROLE_RST  = 3'd3,
      ROLE_OE   = 3'd4
   } pt_role_e;

   typedef enum logic [1:0] {
      MODE_D     = 2'd0,
      MODE_T     = 2'd1,
      MODE_BYP   = 2'd2,
      MODE_BYP_B = 2'd3
   } reg_mode_e;

   typedef struct packed {
      logic clk;
      logic set;
      logic rst;
      logic oe;
      logic oe_used;
   } ctl_s;
endpackage

// File: rtl/mc_pt_alloc.sv
module mc_pt_alloc
   import mc_pkg::*;
#(
   parameter int N_PT = 5
) (
   input  logic [N_PT-1:0]        pt,
   input  logic [N_PT*ROLE_W-1:0] cfg_role,
   output logic                   data_sum,
   output ctl_s                   ctl
);
   logic [N_PT-1:0] is_data;
   logic [N_PT-1:0] is_clk;
   logic [N_PT-1:0] is_set;
   logic [N_PT-1:0] is_rst;
   logic [N_PT-1:0] is_oe;

   for (genvar i = 0; i < N_PT; i++) begin : g_term
      logic [ROLE_W-1:0] code;
      assign code       = cfg_role[i*ROLE_W +: ROLE_W];
      assign is_data[i] = (code == ROLE_DATA);
      assign is_clk[i]  = (code == ROLE_CLK);
      assign is_set[i]  = (code == ROLE_SET);
      assign is_rst[i]  = (code == ROLE_RST);
      assign is_oe[i]   = (code == ROLE_OE);
   end

   assign data_sum    = |(pt & is_data);
   assign ctl.clk     = |(pt & is_clk);
   assign ctl.set     = |(pt & is_set);
   assign ctl.rst     = |(pt & is_rst);
   assign ctl.oe      = |(pt & is_oe);
   assign ctl.oe_used = |is_oe;
endmodule

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
   parameter int N_GCLK = 3,
   localparam int SRC_W = $clog2(N_GCLK + 1)
) (
   input  logic [N_GCLK-1:0] gclk,
   input  logic              pt_clk,
   input  logic [SRC_W-1:0]  src,
   input  logic              inv,
   output logic              reg_clk
);
   always_comb begin
      reg_clk = pt_clk;
      for (int k = 0; k < N_GCLK; k++) begin
         if (src == SRC_W'(k)) reg_clk = gclk[k] ^ inv;
      end
   end
endmodule

// File: rtl/mc_reg.sv
module mc_reg
   import mc_pkg::*;
(
   input  logic      reg_clk,
   input  logic      d,
   input  reg_mode_e mode,
   input  logic      init,
   input  logic      preload,
   input  logic      aset,
   input  logic      arst,
   output logic      q
);
   logic q_reg;
   logic force_any;
   logic force_val;

   assign force_any = init | aset | arst;

   always_comb begin
      if (init)      force_val = preload;
      else if (arst) force_val = 1'b0;
      else           force_val = 1'b1;
   end

   always_ff @(posedge reg_clk or posedge init or posedge aset or posedge arst) begin
      if (force_any) begin
         q_reg <= force_val;
      end else begin
         if (mode == MODE_T) q_reg <= q_reg ^ d;
         else                q_reg <= d;
      end
   end

   // held forcing sources dominate while active
   assign q = force_any ? force_val : q_reg;
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
   import mc_pkg::*;
#(
   parameter int N_PT    = 5,
   parameter int N_GCLK  = 3,
   parameter int N_SHARE = 2,
   localparam int SRC_W  = $clog2(N_GCLK + 1)
) (
   input  logic                   por_n,
   input  logic                   gsr,
   input  logic [N_GCLK-1:0]      gclk,
   input  logic [N_PT-1:0]        pt,
   input  logic [N_SHARE-1:0]     share_in,
   input  logic [N_PT*ROLE_W-1:0] cfg_role,
   input  logic [SRC_W-1:0]       cfg_clk_src,
   input  logic                   cfg_clk_inv,
   input  logic [1:0]             cfg_mode,
   input  logic                   cfg_xor,
   input  logic                   cfg_preload,
   output logic                   mc_out,
   output logic                   mc_fb,
   output logic                   mc_oe
);
   if (N_PT < 1) begin : g_bad_pt
      $error("mc_macrocell: N_PT must be at least 1");
   end
   if (N_GCLK < 1) begin : g_bad_gclk
      $error("mc_macrocell: N_GCLK must be at least 1");
   end
   if (N_SHARE < 1) begin : g_bad_share
      $error("mc_macrocell: N_SHARE must be at least 1");
   end

   logic      direct_sum;
   ctl_s      ctl;
   logic      d_val;
   logic      reg_clk;
   logic      q;
   reg_mode_e mode;

   assign mode = reg_mode_e'(cfg_mode);

   mc_pt_alloc #(.N_PT(N_PT)) u_alloc (
      .pt       (pt),
      .cfg_role (cfg_role),
      .data_sum (direct_sum),
      .ctl      (ctl)
   );

   assign d_val = (direct_sum | (|share_in)) ^ cfg_xor;

   mc_clk_sel #(.N_GCLK(N_GCLK)) u_clk (
      .gclk    (gclk),
      .pt_clk  (ctl.clk),
      .src     (cfg_clk_src),
      .inv     (cfg_clk_inv),
      .reg_clk (reg_clk)
   );

   mc_reg u_reg (
      .reg_clk (reg_clk),
      .d       (d_val),
      .mode    (mode),
      .init    (~por_n | gsr),
      .preload (cfg_preload),
      .aset    (ctl.set),
      .arst    (ctl.rst),
      .q       (q)
   );

   assign mc_out = cfg_mode[1] ? d_val : q;
   assign mc_fb  = q;
   assign mc_oe  = ctl.oe_used ? ctl.oe : 1'b1;
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk
   import mc_pkg::*;
#(
   parameter int N_PT    = 5,
   parameter int N_GCLK  = 3,
   parameter int N_SHARE = 2
) (
   input logic                   por_n,
   input logic                   gsr,
   input logic [N_GCLK-1:0]      gclk,
   input logic [N_PT-1:0]        pt,
   input logic [N_PT*ROLE_W-1:0] cfg_role,
   input logic                   cfg_preload,
   input logic                   mc_fb,
   input logic                   mc_oe
);
   logic set_act, rst_act, oe_act, oe_used;

   always_comb begin
      set_act = 1'b0;
      rst_act = 1'b0;
      oe_act  = 1'b0;
      oe_used = 1'b0;
      for (int i = 0; i < N_PT; i++) begin
         case (cfg_role[i*ROLE_W +: ROLE_W])
            3'd2:    set_act = set_act | pt[i];
            3'd3:    rst_act = rst_act | pt[i];
            3'd4: begin
               oe_act  = oe_act | pt[i];
               oe_used = 1'b1;
            end
            default: ;
         endcase
      end
   end

   AST_RST_WINS: assert property (@(posedge gclk[0]) disable iff (!por_n)
      (rst_act && !gsr) |-> (mc_fb == 1'b0)); // R7
   AST_SET_FORCES: assert property (@(posedge gclk[0]) disable iff (!por_n)
      (set_act && !rst_act && !gsr) |-> (mc_fb == 1'b1)); // R7
   AST_GSR_PRELOAD: assert property (@(posedge gclk[0]) disable iff (!por_n)
      gsr |-> (mc_fb == cfg_preload)); // R8
   AST_OE_DEFAULT: assert property (@(posedge gclk[0]) disable iff (!por_n)
      !oe_used |-> mc_oe); // R11
   AST_OE_FOLLOWS: assert property (@(posedge gclk[0]) disable iff (!por_n)
      oe_used |-> (mc_oe == oe_act)); // R11
endmodule

bind mc_macrocell mc_macrocell_chk #(
   .N_PT(N_PT), .N_GCLK(N_GCLK), .N_SHARE(N_SHARE)
) u_chk (
   .por_n       (por_n),
   .gsr         (gsr),
   .gclk        (gclk),
   .pt          (pt),
   .cfg_role    (cfg_role),
   .cfg_preload (cfg_preload),
   .mc_fb       (mc_fb),
   .mc_oe       (mc_oe)
);

// File: tb/mc_macrocell_bench.sv
module mc_macrocell_bench;
   logic        g0 = 1'b0, g1 = 1'b0, g2 = 1'b0;
   logic [2:0]  gclk;
   logic        por_n, gsr;
   logic [4:0]  pt;
   logic [1:0]  share_in;
   logic [14:0] cfg_role;
   logic [1:0]  cfg_clk_src;
   logic        cfg_clk_inv;
   logic [1:0]  cfg_mode;
   logic        cfg_xor, cfg_preload;
   logic        mc_out, mc_fb, mc_oe;
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   assign gclk = {g2, g1, g0};
   always #4 g0 = ~g0;

   mc_macrocell u_mc_macrocell (
      .por_n(por_n), .gsr(gsr), .gclk(gclk), .pt(pt), .share_in(share_in),
      .cfg_role(cfg_role), .cfg_clk_src(cfg_clk_src), .cfg_clk_inv(cfg_clk_inv),
      .cfg_mode(cfg_mode), .cfg_xor(cfg_xor), .cfg_preload(cfg_preload),
      .mc_out(mc_out), .mc_fb(mc_fb), .mc_oe(mc_oe)
   );

   task automatic chk(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_role(int i, logic [2:0] code);
      cfg_role[i*3 +: 3] = code;
   endtask

   task automatic t_reset();
      por_n = 0; gsr = 0; pt = 0; share_in = 0; cfg_role = 0;
      cfg_clk_src = 0; cfg_clk_inv = 0; cfg_mode = 0; cfg_xor = 0; cfg_preload = 1;
      repeat (2) @(negedge g0);
      #1 chk("R8 power-on loads preload 1", mc_fb, 1'b1);
      chk("R11 oe default", mc_oe, 1'b1);
      cfg_preload = 0;
      #1 chk("R8 power-on loads preload 0", mc_fb, 1'b0);
      por_n = 1;
   endtask

   task automatic t_data_or();
      @(negedge g0); cfg_mode = 2'd2; pt = 5'b00000;
      #1 chk("R2 empty sum", mc_out, 1'b0);
      pt = 5'b00100;
      #1 chk("R2 one direct term", mc_out, 1'b1);
      pt = 0; share_in = 2'b01;
      #1 chk("R2 borrowed term", mc_out, 1'b1);
      share_in = 0; cfg_xor = 1;
      #1 chk("R2 polarity invert", mc_out, 1'b1);
      pt = 5'b10000;
      #1 chk("R2 polarity invert of 1", mc_out, 1'b0);
      cfg_xor = 0; pt = 0;
   endtask

   task automatic t_excluded();
      @(negedge g0); cfg_mode = 2'd3;
      set_role(0, 3'd4); set_role(3, 3'd6);
      pt = 5'b00001;
      #1 chk("R3 oe-role term kept out of sum", mc_out, 1'b0);
      pt = 5'b01000;
      #1 chk("R1 unused code term ignored", mc_out, 1'b0);
      chk("R1 unused code leaves oe", mc_oe, 1'b0);
      pt = 0; cfg_role = 0;
   endtask

   task automatic t_dmode();
      @(negedge g0); cfg_mode = 2'd0; pt = 5'b00010;
      #1 chk("R4 no capture before edge", mc_fb, 1'b0);
      @(posedge g0); #1 chk("R4 captures 1", mc_fb, 1'b1);
      chk("R4 out follows register", mc_out, 1'b1);
      @(negedge g0); pt = 0;
      @(posedge g0); #1 chk("R4 captures 0", mc_fb, 1'b0);
   endtask

   task automatic t_tmode();
      @(negedge g0); cfg_mode = 2'd1; pt = 5'b00001;
      @(posedge g0); #1 chk("R5 toggle to 1", mc_fb, 1'b1);
      @(posedge g0); #1 chk("R5 toggle to 0", mc_fb, 1'b0);
      @(posedge g0); #1 chk("R5 toggle to 1 again", mc_fb, 1'b1);
      @(negedge g0); pt = 0;
      @(posedge g0); #1 chk("R5 hold at 0 input", mc_fb, 1'b1);
      @(posedge g0); #1 chk("R5 still held", mc_fb, 1'b1);
   endtask

   task automatic t_bypass();
      @(negedge g0); cfg_mode = 2'd2; pt = 5'b00000;
      #1 chk("R6 out follows data low", mc_out, 1'b0);
      chk("R6 fb shows register", mc_fb, 1'b1);
      pt = 5'b00100;
      #1 chk("R6 out without clock", mc_out, 1'b1);
      pt = 0;
      @(posedge g0); #1;
      cfg_mode = 2'd0;
   endtask

   task automatic t_async();
      @(negedge g0); pt = 0; cfg_role = 0;
      set_role(1, 3'd2); set_role(2, 3'd3);
      @(posedge g0); #1 chk("R7 baseline 0", mc_fb, 1'b0);
      pt = 5'b00010;
      #1 chk("R7 set acts at once", mc_fb, 1'b1);
      pt = 5'b00110;
      #1 chk("R7 reset wins over set", mc_fb, 1'b0);
      pt = 5'b00000;
      #1 chk("R3 control terms not in sum", mc_out, 1'b0);
      @(negedge g0); pt = 5'b00010;
      #1 chk("R7 set again", mc_fb, 1'b1);
      pt = 0;
   endtask

   task automatic t_gsr();
      @(negedge g0); cfg_preload = 1; pt = 5'b00100; gsr = 1;
      #1 chk("R8 gsr preload over reset term", mc_fb, 1'b1);
      pt = 5'b00010; cfg_preload = 0; gsr = 0; #1 gsr = 1;
      #1 chk("R8 gsr preload over set term", mc_fb, 1'b0);
      pt = 0; gsr = 0; cfg_role = 0;
      @(posedge g0); #1;
   endtask

   task automatic t_clksel();
      @(negedge g0); cfg_mode = 0; pt = 0;
      @(posedge g0); #1 chk("R9 start 0", mc_fb, 1'b0);
      @(negedge g0); cfg_clk_src = 2'd1; pt = 5'b00001;
      @(posedge g0); #1 chk("R9 unselected clock ignored", mc_fb, 1'b0);
      g1 = 1; #1 chk("R9 global clock 1 captures", mc_fb, 1'b1);
      g1 = 0; pt = 0; set_role(4, 3'd1);
      cfg_clk_src = 2'd3;
      @(posedge g0); #1 chk("R9 global 0 ignored under term clock", mc_fb, 1'b1);
      pt = 5'b10000;
      #1 chk("R9 term clock captures", mc_fb, 1'b0);
      pt = 5'b10001;
      #1 chk("R9 no capture while clock held", mc_fb, 1'b0);
      pt = 5'b00001;
      #1 chk("R9 falling term clock ignored", mc_fb, 1'b0);
      pt = 0; cfg_role = 0;
      @(negedge g0); cfg_clk_src = 2'd0;
   endtask

   task automatic t_clkinv();
      @(posedge g0); #1 cfg_clk_inv = 1; pt = 5'b00001;
      #1 chk("R10 no capture on rising edge", mc_fb, 1'b0);
      @(negedge g0); #1 chk("R10 capture on falling edge", mc_fb, 1'b1);
      pt = 0;
      @(posedge g0); #1 chk("R10 rising edge still ignored", mc_fb, 1'b1);
      @(negedge g0); #1 chk("R10 falling edge loads 0", mc_fb, 1'b0);
      cfg_clk_inv = 0;
   endtask

   task automatic t_oe();
      @(negedge g0); cfg_role = 0;
      #1 chk("R11 no oe role gives 1", mc_oe, 1'b1);
      set_role(2, 3'd4); pt = 0;
      #1 chk("R11 oe term low", mc_oe, 1'b0);
      pt = 5'b00100;
      #1 chk("R11 oe term high", mc_oe, 1'b1);
      pt = 0; cfg_role = 0;
   endtask

   initial begin
      t_reset();
      t_data_or();
      t_excluded();
      t_dmode();
      t_tmode();
      t_bypass();
      t_async();
      t_gsr();
      t_clksel();
      t_clkinv();
      t_oe();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule